// File: doc/BRIEF.md
# Low-Power Autoreload Timer

This block is a 16-bit up-counter behind a small register interface. A kernel clock, divided by a power-of-two prescaler, clocks the count. Software turns the timer on, waits for it to arm, and then issues either a one-time run or a repeating run. In both cases the counter climbs from its present value to a programmable reload value and then returns to zero.

The block reports two events through sticky status flags. The first is the counter reaching the reload value. The second is a reload write becoming the value in use. Each flag has its own interrupt enable, and the interrupt line is raised while any enabled flag is set.

Three further options are available. A reload write can be applied at once, or it can be held until the current period ends. Reading the count can clear it. Software can request a delayed counter clear, and that request withdraws itself once it completes. The bus and the kernel run on one clock.

Register map (byte-free word addresses on `bus_addr`):
- 0 control: bit0 on, bit1 one-time start, bit2 repeating start, bit3 clear-count-on-read, bit4 counter clear request. Bits 1 and 2 always read back as 0.
- 1 setup: bits[2:0] prescaler code, bit3 deferred reload.
- 2 reload value. Reading it returns the value in use.
- 3 count. Read only.
- 4 flags. Read only. Bit0 is the reload-reached flag and bit1 is the reload-applied flag.
- 5 interrupt enables. Same bit positions as the flags.
- 6 flag clear. Write only. A 1 in a flag's bit position clears that flag.

Top module: `lpt_timer`

## Requirements
- R1: The prescaler code n (0..7) in setup bits[2:0] makes the count advance once every 2^n kernel cycles. Tick edges fall 2^n, 2·2^n, ... edges after the edge that latched the on bit.
- R2: The timer arms two prescaled ticks after the on bit is set. A start is honoured only when bit0 is 1 in the same control write. A start issued before the timer is armed is held and then runs one cycle after arming. Otherwise a start runs one cycle after its write.
- R3: In repeating mode the count goes 0, 1, ..., reload on successive ticks and then returns to 0 and continues.
- R4: Writing the on bit as 0 stops counting, keeps the count value, and withdraws any start that has not yet run.
- R5: In one-time mode the count returns to 0 on the tick after it reaches the reload value and then stays at 0.
- R6: The reload-reached flag is set on the tick where the count leaves the reload value. `irq` is 1 while any flag is set together with its enable bit.
- R7: With deferred reload off, a reload write takes effect at its write edge and sets the reload-applied flag at that same edge.
- R8: With deferred reload on, a reload write takes effect only at the end of the current period. The reload-applied flag is set at that point, and the reload readback shows the old value until then.
- R9: With clear-on-read set, each read of the count returns the current value and zeroes the count at the end of that read cycle. With it clear, reads have no effect on the count.
- R10: A counter clear request zeroes the count on the third edge after its write. Control bit4 reads 1 until that edge and 0 afterwards.
- R11: Writing 1 to a bit of the flag-clear register clears that flag. Writing 0 leaves the flag unchanged.
- R12: After reset, control, setup, count, flags and enables read 0, reload reads 0xFFFF, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The counting function is tried with random prescaler codes, reload values, modes and start delays. Short start delays land before arming, which separates the held-start path from the direct-start path. Long waits cover many periods, which tells a correct wrap point apart from an off-by-one in either repeating or one-time mode. Directed sequences cover the remaining behaviour. A reload is changed mid-period with deferral on, and the count value shows which limit was used. Back-to-back count reads separate a clearing read from a passive one. The count is also read on each edge around a clear request, to pin down the exact clearing cycle.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int LPT_CNT_W      = 16;
    localparam int LPT_DATA_W     = 16;
    localparam int LPT_ADDR_W     = 3;
    localparam int LPT_PSC_W      = 3;
    localparam int LPT_WARM_TICKS = 2;
    localparam int LPT_RST_DELAY  = 3;

    typedef enum logic [LPT_ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_SETUP  = 3'd1,
        REG_RELOAD = 3'd2,
        REG_COUNT  = 3'd3,
        REG_FLAGS  = 3'd4,
        REG_IEN    = 3'd5,
        REG_FCLR   = 3'd6
    } lpt_addr_e;

    // control register bit positions
    localparam int CTL_ON     = 0;
    localparam int CTL_ONCE   = 1;
    localparam int CTL_REPEAT = 2;
    localparam int CTL_CLR_RD = 3;
    localparam int CTL_ZERO   = 4;

    // setup register: prescaler code in the low bits, deferral flag above
    localparam int SETUP_DEFER = LPT_PSC_W;

    typedef struct packed {
        logic applied;   // bit1: reload write took effect
        logic reached;   // bit0: count left the reload value
    } lpt_flags_t;

    typedef struct packed {
        logic running;
        logic repeat_m;
        logic held;
        logic held_repeat;
    } lpt_run_t;

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int PSC_W = lpt_pkg::LPT_PSC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] code,
    output logic             tick
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] phase;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(code));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) phase <= '0;
        else             phase <= phase + 1'b1;
    end

    assign tick = run && ((phase & mask) == mask);

    // a division above 1 never yields two ticks in a row
    assert_no_back_to_back_R1: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && $past(tick) && $stable(code) && code != '0) |-> !tick)
        else $error("prescaler ticked on consecutive cycles");

endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
#(
    parameter int CNT_W      = LPT_CNT_W,
    parameter int WARM_TICKS = LPT_WARM_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             start_req,
    input  logic             start_repeat,
    input  logic             defer,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wdata,
    input  logic             zero_req,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload_val,
    output logic             wrap_evt,
    output logic             reload_done
);
    localparam int WARM_W = $clog2(WARM_TICKS + 1);

    lpt_run_t          st;
    logic [WARM_W-1:0] warm;
    logic              armed;
    logic [CNT_W-1:0]  next_reload;
    logic              next_valid;

    assign armed       = (warm == WARM_W'(WARM_TICKS));
    assign wrap_evt    = st.running && tick && (count == reload_val);
    assign reload_done = (reload_wr && !defer) || (wrap_evt && next_valid);

    // arming and run control
    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            st   <= '0;
            warm <= '0;
        end else begin
            if (tick && !armed) warm <= warm + 1'b1;
            if (wrap_evt && !st.repeat_m) st.running <= 1'b0;
            if (start_req) begin
                if (armed) begin
                    st.running  <= 1'b1;
                    st.repeat_m <= start_repeat;
                end else begin
                    st.held        <= 1'b1;
                    st.held_repeat <= start_repeat;
                end
            end else if (st.held && armed) begin
                st.running  <= 1'b1;
                st.repeat_m <= st.held_repeat;
                st.held     <= 1'b0;
            end
        end
    end

    // counter
    always_ff @(posedge clk) begin
        if (rst)                       count <= '0;
        else if (zero_req || wrap_evt) count <= '0;
        else if (st.running && tick)   count <= count + 1'b1;
    end

    // reload value, immediate or deferred to the period end
    always_ff @(posedge clk) begin
        if (rst) begin
            reload_val  <= '1;
            next_reload <= '0;
            next_valid  <= 1'b0;
        end else begin
            if (reload_wr && !defer)      reload_val <= reload_wdata;
            else if (wrap_evt && next_valid) reload_val <= next_reload;
            if (reload_wr && defer) begin
                next_reload <= reload_wdata;
                next_valid  <= 1'b1;
            end else if (wrap_evt) begin
                next_valid  <= 1'b0;
            end
        end
    end

    assert_run_only_armed_R2: assert property (@(posedge clk) disable iff (rst)
        st.running |-> armed)
        else $error("counter running before arming");

    assert_off_stops_R4: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !st.running && !st.held)
        else $error("run state survived switch-off");

    assert_once_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap_evt && !st.repeat_m && !start_req) |=> !st.running)
        else $error("one-time run kept going");

    assert_immediate_reload_R7: assert property (@(posedge clk) disable iff (rst)
        (reload_wr && !defer) |=> reload_val == $past(reload_wdata))
        else $error("immediate reload not applied");

    assert_zero_clears_R10: assert property (@(posedge clk) disable iff (rst)
        zero_req |=> count == '0)
        else $error("clear request left a count");

endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int DATA_W    = LPT_DATA_W,
    parameter int ADDR_W    = LPT_ADDR_W,
    parameter int CNT_W     = LPT_CNT_W,
    parameter int PSC_W     = LPT_PSC_W,
    parameter int RST_DELAY = LPT_RST_DELAY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              wrap_evt,
    input  logic              reload_done,
    output logic              enable,
    output logic              start_req,
    output logic              start_repeat,
    output logic [PSC_W-1:0]  psc_code,
    output logic              defer,
    output logic              reload_wr,
    output logic              zero_req,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int DLY_W = $clog2(RST_DELAY + 1);

    logic             clr_rd;
    logic             zero_pend;
    logic [DLY_W-1:0] zero_dly;
    lpt_flags_t       flags;
    logic [1:0]       ien;
    logic             wr_ctrl, wr_fclr, rd_count, zero_due;

    assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
    assign wr_fclr   = bus_wr && (bus_addr == REG_FCLR);
    assign reload_wr = bus_wr && (bus_addr == REG_RELOAD);
    assign rd_count  = bus_rd && (bus_addr == REG_COUNT);
    assign zero_due  = zero_pend && (zero_dly == DLY_W'(RST_DELAY - 1));
    assign zero_req  = zero_due || (rd_count && clr_rd);
    assign irq       = |({flags.applied, flags.reached} & ien);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable       <= 1'b0;
            clr_rd       <= 1'b0;
            start_req    <= 1'b0;
            start_repeat <= 1'b0;
            zero_pend    <= 1'b0;
            zero_dly     <= '0;
            psc_code     <= '0;
            defer        <= 1'b0;
            ien          <= '0;
            flags        <= '0;
        end else begin
            start_req    <= wr_ctrl && bus_wdata[CTL_ON] &&
                            (bus_wdata[CTL_ONCE] || bus_wdata[CTL_REPEAT]);
            start_repeat <= bus_wdata[CTL_REPEAT];
            if (zero_pend) begin
                if (zero_due) begin
                    zero_pend <= 1'b0;
                    zero_dly  <= '0;
                end else begin
                    zero_dly  <= zero_dly + 1'b1;
                end
            end
            if (wr_ctrl) begin
                enable <= bus_wdata[CTL_ON];
                clr_rd <= bus_wdata[CTL_CLR_RD];
                if (bus_wdata[CTL_ZERO] && !zero_pend) zero_pend <= 1'b1;
            end
            if (bus_wr && bus_addr == REG_SETUP) begin
                psc_code <= bus_wdata[PSC_W-1:0];
                defer    <= bus_wdata[SETUP_DEFER];
            end
            if (bus_wr && bus_addr == REG_IEN) ien <= bus_wdata[1:0];
            flags.reached <= wrap_evt    || (flags.reached && !(wr_fclr && bus_wdata[0]));
            flags.applied <= reload_done || (flags.applied && !(wr_fclr && bus_wdata[1]));
        end
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL:   bus_rdata = DATA_W'({zero_pend, clr_rd, 2'b00, enable});
            REG_SETUP:  bus_rdata = DATA_W'({defer, psc_code});
            REG_RELOAD: bus_rdata = DATA_W'(reload_val);
            REG_COUNT:  bus_rdata = DATA_W'(count);
            REG_FLAGS:  bus_rdata = DATA_W'(flags);
            REG_IEN:    bus_rdata = DATA_W'(ien);
            default:    bus_rdata = '0;
        endcase
    end

    assert_reached_sets_R6: assert property (@(posedge clk) disable iff (rst)
        wrap_evt |=> flags.reached)
        else $error("reach event lost");

    assert_clear_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_fclr && bus_wdata[0] && !wrap_evt) |=> !flags.reached)
        else $error("flag clear ignored");

    assert_zero_selfclear_R10: assert property (@(posedge clk) disable iff (rst)
        (zero_due && !(wr_ctrl && bus_wdata[CTL_ZERO])) |=> !zero_pend)
        else $error("clear request did not withdraw");

endmodule

// File: rtl/lpt_timer.sv
module lpt_timer
    import lpt_pkg::*;
#(
    parameter int DATA_W     = LPT_DATA_W,
    parameter int ADDR_W     = LPT_ADDR_W,
    parameter int CNT_W      = LPT_CNT_W,
    parameter int PSC_W      = LPT_PSC_W,
    parameter int WARM_TICKS = LPT_WARM_TICKS,
    parameter int RST_DELAY  = LPT_RST_DELAY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             enable, start_req, start_repeat, defer;
    logic             reload_wr, zero_req, tick, wrap_evt, reload_done;
    logic [PSC_W-1:0] psc_code;
    logic [CNT_W-1:0] count, reload_val;

    lpt_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .PSC_W(PSC_W), .RST_DELAY(RST_DELAY)
    ) regs_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .count(count), .reload_val(reload_val),
        .wrap_evt(wrap_evt), .reload_done(reload_done),
        .enable(enable), .start_req(start_req), .start_repeat(start_repeat),
        .psc_code(psc_code), .defer(defer), .reload_wr(reload_wr),
        .zero_req(zero_req), .bus_rdata(bus_rdata), .irq(irq)
    );

    lpt_prescaler #(.PSC_W(PSC_W)) psc_i (
        .clk(clk), .rst(rst), .run(enable), .code(psc_code), .tick(tick)
    );

    lpt_core #(.CNT_W(CNT_W), .WARM_TICKS(WARM_TICKS)) core_i (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick),
        .start_req(start_req), .start_repeat(start_repeat), .defer(defer),
        .reload_wr(reload_wr), .reload_wdata(CNT_W'(bus_wdata)),
        .zero_req(zero_req), .count(count), .reload_val(reload_val),
        .wrap_evt(wrap_evt), .reload_done(reload_done)
    );

endmodule

// File: tb/lpt_timer_tb_top.sv
`timescale 1ns/1ps
module lpt_timer_tb_top;

    localparam logic [2:0] A_CTRL = 3'd0, A_SETUP = 3'd1, A_RELOAD = 3'd2,
                           A_COUNT = 3'd3, A_FLAGS = 3'd4, A_IEN = 3'd5, A_FCLR = 3'd6;
    localparam logic [15:0] ON = 16'h1, ONCE = 16'h2, REP = 16'h4,
                            CLRRD = 16'h8, ZERO = 16'h10, DEFER = 16'h8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpt_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // every bus task starts and ends at a falling edge and spans one rising edge
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    // tick edges lie at w+d, w+2d, ...; count those in (a, b]
    function automatic int ticks(input int w, input int d, input int a, input int b);
        if (b <= a) return 0;
        return (b - w) / d - (a - w) / d;
    endfunction

    // edge after which the run begins, given on-edge w and start-write edge s
    function automatic int run_from(input int w, input int d, input int s);
        return (s + 1 > w + 2 * d + 1) ? s + 1 : w + 2 * d + 1;
    endfunction

    function automatic int exp_count(input int t, input int r, input bit rep);
        if (rep) return t % (r + 1);
        return (t <= r) ? t : 0;
    endfunction

    task automatic quiesce();
        wr(A_CTRL, ZERO);
        idle(4);
        wr(A_SETUP, 16'h0);
        wr(A_FCLR, 16'h3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, v2, w, s, e, c, x, rf;
        idle(4);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        rd(A_CTRL, v);   check("R12 ctrl", v, 0);
        rd(A_SETUP, v);  check("R12 setup", v, 0);
        rd(A_RELOAD, v); check("R12 reload", v, 16'hFFFF);
        rd(A_COUNT, v);  check("R12 count", v, 0);
        rd(A_FLAGS, v);  check("R12 flags", v, 0);
        rd(A_IEN, v);    check("R12 ien", v, 0);
        check("R12 irq", int'(irq), 0);

        // R2 start held until armed, division 1
        wr(A_RELOAD, 16'd100);
        wr(A_CTRL, ON | REP); w = cyc;
        idle(3);
        rd(A_COUNT, v); check("R2 held start not yet counting", v, 0);
        rd(A_COUNT, v); check("R2 first tick after arming", v, 1);
        // R2 start without the on bit is ignored
        quiesce();
        wr(A_CTRL, REP);
        wr(A_CTRL, ON);
        idle(30);
        rd(A_COUNT, v); check("R2 start without on ignored", v, 0);

        // R3 repeating wrap
        quiesce();
        wr(A_RELOAD, 16'd5);
        wr(A_CTRL, ON | REP); w = cyc; rf = run_from(w, 1, w);
        idle(20); e = cyc;
        rd(A_COUNT, v); check("R3 repeat count", v, exp_count(ticks(w, 1, rf, e), 5, 1));
        idle(7); e = cyc;
        rd(A_COUNT, v); check("R3 repeat count later", v, exp_count(ticks(w, 1, rf, e), 5, 1));

        // R1 division by 4
        quiesce();
        wr(A_SETUP, 16'd2);
        wr(A_RELOAD, 16'd1000);
        wr(A_CTRL, ON | REP); w = cyc; rf = run_from(w, 4, w);
        idle(41); e = cyc;
        rd(A_COUNT, v); check("R1 divide by 4", v, ticks(w, 4, rf, e));

        // R5 one-time run, R6 flag and irq, R11 flag clear
        quiesce();
        wr(A_RELOAD, 16'd4);
        wr(A_FCLR, 16'h3);
        wr(A_IEN, 16'h1);
        wr(A_CTRL, ON | ONCE);
        idle(30);
        rd(A_COUNT, v); check("R5 one-time ends at zero", v, 0);
        rd(A_FLAGS, v); check("R6 reached flag", v, 1);
        check("R6 irq raised", int'(irq), 1);
        idle(20);
        rd(A_COUNT, v); check("R5 stays at zero", v, 0);
        wr(A_FCLR, 16'h0);
        rd(A_FLAGS, v); check("R11 zero write keeps flag", v, 1);
        wr(A_FCLR, 16'h1);
        rd(A_FLAGS, v); check("R11 flag cleared", v, 0);
        check("R6 irq dropped", int'(irq), 0);

        // R7 immediate reload
        wr(A_IEN, 16'h2);
        wr(A_RELOAD, 16'h1234);
        rd(A_RELOAD, v); check("R7 reload applied", v, 16'h1234);
        rd(A_FLAGS, v);  check("R7 applied flag", (v >> 1) & 1, 1);
        check("R7 irq on applied", int'(irq), 1);
        wr(A_FCLR, 16'h2);
        wr(A_IEN, 16'h0);

        // R8 deferred reload
        quiesce();
        wr(A_RELOAD, 16'd9);
        wr(A_SETUP, DEFER);
        wr(A_FCLR, 16'h3);
        wr(A_CTRL, ON | REP); w = cyc; rf = run_from(w, 1, w);
        wait_until(rf + 1);
        wr(A_RELOAD, 16'd3);
        rd(A_RELOAD, v); check("R8 old reload still in use", v, 9);
        rd(A_FLAGS, v);  check("R8 not yet applied", (v >> 1) & 1, 0);
        wait_until(rf + 6); e = cyc;
        rd(A_COUNT, v);  check("R8 counts past new limit", v, e - rf);
        wait_until(rf + 16); e = cyc;
        rd(A_COUNT, v);  check("R8 new period after wrap", v, (e - rf - 10) % 4);
        rd(A_FLAGS, v);  check("R8 applied at period end", (v >> 1) & 1, 1);
        rd(A_RELOAD, v); check("R8 new reload readback", v, 3);

        // R9 clear on read
        quiesce();
        wr(A_RELOAD, 16'd1000);
        wr(A_CTRL, ON | REP); w = cyc; rf = run_from(w, 1, w);
        wait_until(w + 20);
        wr(A_CTRL, ON | CLRRD); e = cyc;
        rd(A_COUNT, v); check("R9 read returns value", v, e - rf);
        c = cyc;
        rd(A_COUNT, v); check("R9 count zeroed by read", v, 0);
        wait_until(c + 6);
        rd(A_COUNT, v); check("R9 counts on after clear", v, 5);
        wr(A_CTRL, ON);
        rd(A_COUNT, v); rd(A_COUNT, v2);
        check("R9 plain reads leave count", v2, v + 1);

        // R10 delayed counter clear
        wr(A_CTRL, ON | ZERO); x = cyc;
        rd(A_CTRL, v);  check("R10 request pending", v, 16'h11);
        rd(A_COUNT, v); check("R10 not cleared after 1", int'(v != 0), 1);
        rd(A_COUNT, v); check("R10 not cleared after 2", int'(v != 0), 1);
        rd(A_COUNT, v); check("R10 cleared on third edge", v, 0);
        rd(A_CTRL, v);  check("R10 request withdrawn", v, 16'h1);
        rd(A_COUNT, v); check("R10 counts on", v, 2);

        // R4 switch-off holds the count and drops a held start
        wr(A_CTRL, 16'h0);
        rd(A_COUNT, v);
        idle(20);
        rd(A_COUNT, v2); check("R4 count held when off", v2, v);
        quiesce();
        wr(A_SETUP, 16'd3);
        wr(A_CTRL, ON | REP);
        wr(A_CTRL, 16'h0);
        wr(A_CTRL, ON);
        idle(60);
        rd(A_COUNT, v); check("R4 held start withdrawn", v, 0);

        // random runs
        void'($urandom(32'h5eed_0042));
        for (int it = 0; it < 25; it++) begin
            int code, d, r, rep, dl, t;
            quiesce();
            code = $urandom % 4; d = 1 << code;
            r = 2 + $urandom % 30;
            rep = $urandom % 2;
            wr(A_SETUP, 16'(code));
            wr(A_RELOAD, 16'(r));
            wr(A_CTRL, ON); w = cyc;
            dl = $urandom % 12;
            idle(dl);
            wr(A_CTRL, ON | (rep ? REP : ONCE)); s = cyc;
            rf = run_from(w, d, s);
            idle($urandom % 200);
            e = cyc;
            t = ticks(w, d, rf, e);
            rd(A_COUNT, v);
            check(rep ? "R3 random repeat" : "R5 random one-time", v, exp_count(t, r, rep[0]));
            e = cyc;
            t = ticks(w, d, rf, e);
            rd(A_FLAGS, v);
            check("R6 random reached flag", v & 1, int'(t > r));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule